// File: doc/BRIEF.md
# Descriptor-Chained DMA Sequencer

This block steps a DMA channel through a chain of transfer descriptors held in a table in host memory. Software sets the table base and then writes one control word. That word carries the number of descriptors and two option bits. The sequencer reads each four-dword descriptor in table order and hands its length and two addresses to a transfer engine through a request/done handshake. It then moves on to the next entry.

Completion is reported in several ways. The sequencer keeps the number of the last descriptor completed. It can write that number back into the table header after the first descriptor and after the last one. It can also raise an MSI request when the chain ends. A cycle counter measures the time from start to finish. The same block serves a read channel and a write channel, one instance each.

Table layout, as byte offsets from the base:
- The header takes 16 bytes. The write-back slot is the header's fourth dword, at base+12.
- Descriptor i (counting from 0) starts at base+16+16*i.
- Descriptor dword 0: bits [15:0] hold the length in dwords, and bit 18 is the per-descriptor write-back enable.
- Descriptor dword 1 is reserved and ignored.
- Descriptor dword 2 is the local address.
- Descriptor dword 3 is the host address.

Top module: `chain_dma_seq`

## Requirements
- R1: After reset, busy, all four request outputs, last_num and perf_cnt are 0.
- R2: A control write while idle starts a chain of ctl_wdata[15:0] descriptors. Busy rises on the next cycle. Each descriptor's four dwords are read one per rd_req/rd_ack handshake, at base+16+16*i+4*w for w = 0..3, and descriptors are read in ascending order.
- R3: After the four dwords of a descriptor have been read, xfer_req is driven with xfer_len = dword0[15:0], xfer_laddr = dword2 and xfer_haddr = dword3. xfer_req is held until xfer_done, and no read of the next descriptor starts before xfer_done.
- R4: When descriptor i (0-based) completes, last_num becomes i+1. Starting a new chain clears last_num to 0.
- R5: Write-back for descriptor i is enabled when control bit 18 OR dword0 bit 18 of that descriptor is set. When enabled, and only when i is the first or the last descriptor, the value i+1 is written to base+12 through wb_req/wb_ack before the chain continues. A chain of one descriptor writes back once.
- R6: When control bit 17 is set, msi_req is raised after the last transfer and after any write-back, and it is held until msi_ack. When bit 17 is clear, no MSI request is made.
- R7: Busy stays high until the final write-back and MSI handshakes are complete, then returns to 0.
- R8: A control write while busy is ignored: the running chain keeps its descriptor count and options.
- R9: A count of zero issues no read, transfer or write-back. It completes after one busy cycle, with an MSI request if bit 17 is set.
- R10: perf_cnt is cleared at start. It then equals the number of cycles busy was high, and it holds that value after completion.
- R11: At most one of rd_req, xfer_req, wb_req and msi_req is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tbl_base | input | AW | Descriptor table byte address, sampled at start |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control word: [15:0] count, [17] MSI enable, [18] write-back enable |
| rd_req | output | 1 | Descriptor dword read request |
| rd_addr | output | AW | Descriptor dword byte address |
| rd_ack | input | 1 | Read response strobe |
| rd_data | input | 32 | Read response dword |
| xfer_req | output | 1 | Transfer request, held until done |
| xfer_len | output | 16 | Transfer length in dwords |
| xfer_laddr | output | 32 | Local address |
| xfer_haddr | output | 32 | Host address |
| xfer_done | input | 1 | Transfer complete strobe |
| wb_req | output | 1 | Write-back request |
| wb_addr | output | AW | Write-back byte address (base+12) |
| wb_data | output | 16 | Last completed descriptor number |
| wb_ack | input | 1 | Write-back accepted |
| msi_req | output | 1 | MSI request |
| msi_ack | input | 1 | MSI accepted |
| busy | output | 1 | Chain in progress |
| last_num | output | 16 | Number of the last descriptor completed |
| perf_cnt | output | 32 | Busy cycle count of the current or last chain |

## Verification
The vector table varies the chain length over one, two and several descriptors. It also varies the MSI option and the control-level and per-descriptor write-back enables. Per-descriptor enable masks that set bits only on middle entries show whether write-back is limited to the first and last descriptor. Masks that set only the first or only the last entry show that the two enables are ORed per descriptor. Transfers are checked in order, field by field, which exposes any addressing or dword-order slip in the fetch. Directed runs cover a zero-length chain and a control write made during a busy chain.

// File: rtl/chain_dma_seq.sv
module chain_dma_seq #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] tbl_base,
  input  logic          ctl_wr,
  input  logic [31:0]   ctl_wdata,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [31:0]   rd_data,
  output logic          xfer_req,
  output logic [15:0]   xfer_len,
  output logic [31:0]   xfer_laddr,
  output logic [31:0]   xfer_haddr,
  input  logic          xfer_done,
  output logic          wb_req,
  output logic [AW-1:0] wb_addr,
  output logic [CW-1:0] wb_data,
  input  logic          wb_ack,
  output logic          msi_req,
  input  logic          msi_ack,
  output logic          busy,
  output logic [CW-1:0] last_num,
  output logic [PW-1:0] perf_cnt
);
  localparam int MSI_BIT = 17;
  localparam int WB_BIT  = 18;
  localparam logic [AW-1:0] HDR_BYTES = AW'(16);
  localparam logic [AW-1:0] WB_OFS    = AW'(12);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_XFER, S_WB, S_NEXT, S_MSI} st_t;
  st_t st;

  logic [AW-1:0] base_q;
  logic [CW-1:0] cnt_q, idx_q;
  logic          irq_q, cwb_q;
  logic [1:0]    word_q;
  logic [31:0]   dw0_q, dw2_q, dw3_q;

  wire start   = ctl_wr && (st == S_IDLE);
  wire desc_wb = cwb_q || dw0_q[WB_BIT];
  wire edge_ix = (idx_q == '0) || (idx_q + 1'b1 == cnt_q);

  assign busy       = (st != S_IDLE);
  assign rd_req     = (st == S_FETCH);
  assign xfer_req   = (st == S_XFER);
  assign wb_req     = (st == S_WB);
  assign msi_req    = (st == S_MSI);
  assign rd_addr    = base_q + HDR_BYTES + (AW'(idx_q) << 4) + (AW'(word_q) << 2);
  assign wb_addr    = base_q + WB_OFS;
  assign wb_data    = last_num;
  assign xfer_len   = dw0_q[15:0];
  assign xfer_laddr = dw2_q;
  assign xfer_haddr = dw3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      base_q   <= '0;
      cnt_q    <= '0;
      idx_q    <= '0;
      irq_q    <= 1'b0;
      cwb_q    <= 1'b0;
      word_q   <= '0;
      dw0_q    <= '0;
      dw2_q    <= '0;
      dw3_q    <= '0;
      last_num <= '0;
      perf_cnt <= '0;
    end else begin
      if (start) perf_cnt <= '0;
      else if (busy) perf_cnt <= perf_cnt + 1'b1;
      case (st)
        S_IDLE: if (ctl_wr) begin
          base_q   <= tbl_base;
          cnt_q    <= ctl_wdata[CW-1:0];
          irq_q    <= ctl_wdata[MSI_BIT];
          cwb_q    <= ctl_wdata[WB_BIT];
          idx_q    <= '0;
          word_q   <= '0;
          last_num <= '0;
          st       <= S_NEXT;
        end
        S_FETCH: if (rd_ack) begin
          case (word_q)
            2'd0: dw0_q <= rd_data;
            2'd2: dw2_q <= rd_data;
            2'd3: dw3_q <= rd_data;
            default: ;
          endcase
          word_q <= word_q + 1'b1;
          if (word_q == 2'd3) st <= S_XFER;
        end
        S_XFER: if (xfer_done) begin
          last_num <= idx_q + 1'b1;
          st       <= (desc_wb && edge_ix) ? S_WB : S_NEXT;
        end
        S_WB: if (wb_ack) st <= S_NEXT;
        S_NEXT: begin
          if (last_num == cnt_q) st <= irq_q ? S_MSI : S_IDLE;
          else begin
            idx_q  <= last_num;
            word_q <= '0;
            st     <= S_FETCH;
          end
        end
        S_MSI: if (msi_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r11_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req, xfer_req, wb_req, msi_req}));

  a_r3_xfer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_done) |=> xfer_req);

  a_r3_xfer_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_done) |=> $stable(xfer_len) && $stable(xfer_laddr) && $stable(xfer_haddr));

  a_r2_rd_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> $stable(rd_addr));

  a_r8_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctl_wr) |=> $stable(cnt_q) && $stable(irq_q) && $stable(cwb_q));

  a_r4_last_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (last_num <= cnt_q));

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(rd_req || xfer_req || wb_req || msi_req));

  a_r6_msi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_req && !msi_ack) |=> msi_req);
endmodule

// File: tb/sim_chain_dma_seq.sv
module sim_chain_dma_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] tbl_base = 32'h0000_4000;
  logic ctl_wr = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic rd_req, xfer_req, wb_req, msi_req, busy;
  logic [31:0] rd_addr, wb_addr;
  logic rd_ack = 1'b0, xfer_done = 1'b0, wb_ack = 1'b0, msi_ack = 1'b0;
  logic [31:0] rd_data = '0;
  logic [15:0] xfer_len, wb_data, last_num;
  logic [31:0] xfer_laddr, xfer_haddr, perf_cnt;

  chain_dma_seq u0 (.clk(clk), .rst_n(rst_n), .tbl_base(tbl_base), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
    .rd_data(rd_data), .xfer_req(xfer_req), .xfer_len(xfer_len), .xfer_laddr(xfer_laddr),
    .xfer_haddr(xfer_haddr), .xfer_done(xfer_done), .wb_req(wb_req), .wb_addr(wb_addr),
    .wb_data(wb_data), .wb_ack(wb_ack), .msi_req(msi_req), .msi_ack(msi_ack),
    .busy(busy), .last_num(last_num), .perf_cnt(perf_cnt));

  int n_tests = 0, n_fail = 0;
  int mask = 0;
  int rd_n, xf_n, wb_n, msi_n, busy_n, rd_bad, xdly;
  logic [15:0] xl_len [16];
  logic [31:0] xl_la [16], xl_ha [16];
  logic [15:0] wl_dat [16];
  logic [31:0] wl_adr [16];

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    int i, w;
    i = int'((a - tbl_base - 32'd16) >> 4);
    w = int'(a[3:2]);
    case (w)
      0: return 32'(8 + 3*i) | (((mask >> i) & 1) != 0 ? 32'h0004_0000 : 32'h0);
      1: return 32'hDEAD_BEEF;
      2: return 32'h1000_0000 + 32'(i*256);
      default: return 32'h2000_0000 + 32'(i*64);
    endcase
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (busy) busy_n++;
    if (rd_req && !rd_ack) begin
      if (rd_addr != tbl_base + 32'd16 + 32'(rd_n*4)) rd_bad++;
      rd_data <= mem_word(rd_addr);
      rd_ack <= 1'b1;
      rd_n++;
    end else rd_ack <= 1'b0;
    if (xfer_req && !xfer_done) begin
      if (xdly == 2) begin
        xl_len[xf_n] = xfer_len; xl_la[xf_n] = xfer_laddr; xl_ha[xf_n] = xfer_haddr;
        xf_n++; xdly = 0; xfer_done <= 1'b1;
      end else xdly++;
    end else xfer_done <= 1'b0;
    if (wb_req && !wb_ack) begin
      wl_dat[wb_n] = wb_data; wl_adr[wb_n] = wb_addr; wb_n++; wb_ack <= 1'b1;
    end else wb_ack <= 1'b0;
    if (msi_req && !msi_ack) begin msi_n++; msi_ack <= 1'b1; end
    else msi_ack <= 1'b0;
  end

  task automatic run(input int cnt, input int irq, input int cwb, input int m, input bit poke);
    int guard;
    mask = m;
    rd_n = 0; xf_n = 0; wb_n = 0; msi_n = 0; busy_n = 0; rd_bad = 0; xdly = 0;
    @(negedge clk);
    ctl_wdata = 32'(cnt) | (irq != 0 ? 32'h0002_0000 : 0) | (cwb != 0 ? 32'h0004_0000 : 0);
    ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
    check("R2 busy after start", busy, 1);
    if (poke) begin
      @(negedge clk);
      ctl_wdata = 32'h0006_0009; ctl_wr = 1'b1;
      @(negedge clk);
      ctl_wr = 1'b0;
    end
    guard = 0;
    while (busy && guard < 5000) begin @(negedge clk); guard++; end
    check("R7 busy returns low", busy, 0);
  endtask

  task automatic verify(input int cnt, input int irq, input int cwb, input int m);
    int ew;
    check("R2 read count", rd_n, 4*cnt);
    check("R2 read addresses in order", rd_bad, 0);
    check("R3 transfer count", xf_n, cnt);
    for (int i = 0; i < cnt && i < xf_n; i++) begin
      check("R3 xfer_len", xl_len[i], 8 + 3*i);
      check("R3 xfer_laddr", xl_la[i], 32'h1000_0000 + 32'(i*256));
      check("R3 xfer_haddr", xl_ha[i], 32'h2000_0000 + 32'(i*64));
    end
    ew = 0;
    for (int i = 0; i < cnt; i++) begin
      if ((cwb != 0 || ((m >> i) & 1) != 0) && (i == 0 || i == cnt-1)) begin
        if (ew < wb_n) begin
          check("R5 write-back value", wl_dat[ew], i + 1);
          check("R5 write-back address", wl_adr[ew], tbl_base + 32'd12);
        end
        ew++;
      end
    end
    check("R5 write-back count", wb_n, ew);
    check("R6 msi count", msi_n, irq);
    check("R4 last_num", last_num, cnt);
    check("R10 perf_cnt", perf_cnt, busy_n);
  endtask

  localparam int NV = 7;
  localparam int V_CNT [NV] = '{3, 1, 4, 5, 2, 4, 6};
  localparam int V_IRQ [NV] = '{1, 0, 1, 0, 1, 0, 1};
  localparam int V_CWB [NV] = '{0, 1, 1, 0, 0, 0, 0};
  localparam int V_MSK [NV] = '{0, 0, 0, 14, 1, 8, 33};

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    check("R1 reset busy", busy, 0);
    check("R1 reset requests", {rd_req, xfer_req, wb_req, msi_req}, 0);
    check("R1 reset last_num", last_num, 0);
    check("R1 reset perf_cnt", perf_cnt, 0);
    rst_n = 1'b1;
    for (int v = 0; v < NV; v++) begin
      run(V_CNT[v], V_IRQ[v], V_CWB[v], V_MSK[v], 1'b0);
      verify(V_CNT[v], V_IRQ[v], V_CWB[v], V_MSK[v]);
    end
    run(0, 0, 1, 0, 1'b0);
    check("R9 zero count transfers", xf_n + rd_n + wb_n, 0);
    check("R9 zero count busy cycles", busy_n, 1);
    check("R4 zero count last_num cleared", last_num, 0);
    check("R10 zero count perf", perf_cnt, 1);
    run(0, 1, 0, 0, 1'b0);
    check("R9 zero count msi", msi_n, 1);
    run(2, 0, 0, 0, 1'b1);
    verify(2, 0, 0, 0);
    check("R8 write while busy ignored, no msi", msi_n, 0);
    repeat (4) @(negedge clk);
    check("R11 idle after run", {rd_req, xfer_req, wb_req, msi_req}, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule